// File: doc/BRIEF.md
# Dual-Port Hardware Semaphore Unit

This block keeps a bank of hardware ownership flags that two independent processor ports share, for example the two sides of a shared memory. Each side has a select, a write strobe, a read strobe, a flag index and one write data bit. Writing a zero to a flag asks for it. Writing a one gives it back, or withdraws a request that has not been granted yet. Reading a flag returns zero on every read data bit when the reading side owns that flag. It returns all ones when the flag is free or belongs to the other side.

Software claims a flag with a write followed by a read-back. A request stays latched, so a side that lost the flag becomes owner without writing again as soon as the holder lets it go. Flags carry no fixed meaning. Each side decides for itself which region of the shared resource a flag guards.

Every access finishes in one cycle and the block never stalls a port. For this reason the ports are plain strobes with no valid/ready handshake and no back-pressure. The read data is combinational from the registered ownership state. A write registers on the clock edge, and a read in the next cycle sees its effect.

Top module: `dual_sem_unit`

## Requirements
- R1: After reset every flag is free. A read of any flag from either port returns all ones.
- R2: When a port writes 0 (write data bit = 0) to a flag the other port does not own, that port owns the flag from the next clock edge. A read by that port in the following cycle returns all zeros.
- R3: A read of a flag owned by the other port, or of a free flag, returns all ones. The read data is the ownership result of bit 0, copied onto every read data bit.
- R4: When the owner writes 1 to its flag and no request is pending on the other side, the flag becomes free at that clock edge.
- R5: A request that is pending on the other side is granted at the same clock edge that registers the owner's release, with no new write. The new owner's next read returns all zeros.
- R6: When a port that does not own a flag writes 1 to it, only its own pending request is cleared. The owner keeps the flag, and a later release leaves the flag free.
- R7: When both ports write 0 to the same free flag on the same clock edge, the left port wins and the right request stays pending.
- R8: Flags are independent. A write to one index changes no other flag.
- R9: Strobes are ignored while the port's select is low. Read data is all ones whenever the port is not reading.
- R10: A flag is never owned by both ports at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs | input | 1 | Left port select |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_idx | input | IDX_W | Left flag index |
| l_wdat | input | 1 | Left write bit: 0 request, 1 release |
| l_rdat | output | DATA_W | Left read data: all 0 when owned, else all 1 |
| r_cs | input | 1 | Right port select |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_idx | input | IDX_W | Right flag index |
| r_wdat | input | 1 | Right write bit: 0 request, 1 release |
| r_rdat | output | DATA_W | Right read data: all 0 when owned, else all 1 |

## Verification
The bench builds the block with its defaults: eight flags (a 3-bit index) and an 8-bit read bus. With only eight flags, the bench can sweep every index from both sides after reset, and the independence checks cover the whole bank. The 8-bit bus lets the bench see whether the ownership bit is copied onto all read bits. A behavioural model of each flag's owner and of both sides' pending requests is compared with both read buses on every clock. The directed sequences cover hand-over, withdrawal and simultaneous requests.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    SEM_FREE  = 2'd0,
    SEM_LEFT  = 2'd1,
    SEM_RIGHT = 2'd2
  } sem_owner_e;
endpackage

// File: rtl/sem_req_bank.sv
module sem_req_bank #(
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs,
  input  logic                 wr,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 wdat,
  output logic [NUM_FLAGS-1:0] want_nxt
);
  logic [NUM_FLAGS-1:0] want_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_req
    logic hit;
    assign hit = cs && wr && (idx == IDX_W'(g));
    // request is active when a zero was written
    assign want_nxt[g] = hit ? ~wdat : want_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) want_q[g] <= 1'b0;
      else        want_q[g] <= want_nxt[g];
    end
  end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want_l,
  input  logic want_r,
  output logic own_l,
  output logic own_r
);
  sem_owner_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      SEM_FREE: begin
        if (want_l)      st_d = SEM_LEFT;
        else if (want_r) st_d = SEM_RIGHT;
      end
      SEM_LEFT: begin
        if (!want_l) st_d = want_r ? SEM_RIGHT : SEM_FREE;
      end
      SEM_RIGHT: begin
        if (!want_r) st_d = want_l ? SEM_LEFT : SEM_FREE;
      end
      default: st_d = SEM_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEM_FREE;
    else        st_q <= st_d;
  end

  assign own_l = (st_q == SEM_LEFT);
  assign own_r = (st_q == SEM_RIGHT);
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic                 cs,
  input  logic                 rd,
  input  logic [IDX_W-1:0]     idx,
  input  logic [NUM_FLAGS-1:0] owned,
  output logic [DATA_W-1:0]    rdat
);
  logic sel_own;
  assign sel_own = (int'(idx) < NUM_FLAGS) ? owned[idx] : 1'b0;
  assign rdat    = (cs && rd) ? {DATA_W{~sel_own}} : {DATA_W{1'b1}};
endmodule

// File: rtl/dual_sem_unit.sv
module dual_sem_unit #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [IDX_W-1:0]  l_idx,
  input  logic              l_wdat,
  output logic [DATA_W-1:0] l_rdat,
  input  logic              r_cs,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [IDX_W-1:0]  r_idx,
  input  logic              r_wdat,
  output logic [DATA_W-1:0] r_rdat
);
  logic [NUM_FLAGS-1:0] want_l, want_r;
  logic [NUM_FLAGS-1:0] own_l, own_r;

  sem_req_bank #(.NUM_FLAGS(NUM_FLAGS)) u_req_l (
    .clk(clk), .rst_n(rst_n), .cs(l_cs), .wr(l_wr),
    .idx(l_idx), .wdat(l_wdat), .want_nxt(want_l)
  );

  sem_req_bank #(.NUM_FLAGS(NUM_FLAGS)) u_req_r (
    .clk(clk), .rst_n(rst_n), .cs(r_cs), .wr(r_wr),
    .idx(r_idx), .wdat(r_wdat), .want_nxt(want_r)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .want_l(want_l[g]), .want_r(want_r[g]),
      .own_l(own_l[g]), .own_r(own_r[g])
    );
  end

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
    .cs(l_cs), .rd(l_rd), .idx(l_idx), .owned(own_l), .rdat(l_rdat)
  );

  sem_read_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
    .cs(r_cs), .rd(r_rd), .idx(r_idx), .owned(own_r), .rdat(r_rdat)
  );
endmodule

// File: rtl/sem_checker.sv
module sem_checker #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 l_cs, l_wr, l_rd, l_wdat,
  input logic [IDX_W-1:0]     l_idx,
  input logic [DATA_W-1:0]    l_rdat,
  input logic                 r_cs, r_wr, r_rd, r_wdat,
  input logic [IDX_W-1:0]     r_idx,
  input logic [DATA_W-1:0]    r_rdat,
  input logic [NUM_FLAGS-1:0] own_l,
  input logic [NUM_FLAGS-1:0] own_r
);
  logic l_req, r_req, l_rel;
  assign l_req = l_cs && l_wr && !l_wdat;
  assign r_req = r_cs && r_wr && !r_wdat;
  assign l_rel = l_cs && l_wr && l_wdat;

  assert_mutex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (own_l & own_r) == '0);

  assert_idle_ones_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_cs && l_rd) |-> (l_rdat == {DATA_W{1'b1}}));

  assert_no_double_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_cs && l_rd && r_cs && r_rd && l_idx == r_idx) |-> (l_rdat[0] || r_rdat[0]));

  assert_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (l_req && !own_r[l_idx]) |=> own_l[$past(l_idx)]);

  assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rel && own_l[l_idx]) |=> !own_l[$past(l_idx)]);

  assert_left_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (l_req && r_req && l_idx == r_idx && !own_l[l_idx] && !own_r[l_idx])
    |=> (own_l[$past(l_idx)] && !own_r[$past(l_idx)]));
endmodule

bind dual_sem_unit sem_checker #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_sem_chk (
  .clk(clk), .rst_n(rst_n),
  .l_cs(l_cs), .l_wr(l_wr), .l_rd(l_rd), .l_wdat(l_wdat), .l_idx(l_idx), .l_rdat(l_rdat),
  .r_cs(r_cs), .r_wr(r_wr), .r_rd(r_rd), .r_wdat(r_wdat), .r_idx(r_idx), .r_rdat(r_rdat),
  .own_l(own_l), .own_r(own_r)
);

// File: tb/tb_dual_sem_unit.sv
module tb_dual_sem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 8;
  localparam int DW = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs = 0, l_wr = 0, l_rd = 0, l_wdat = 1;
  logic r_cs = 0, r_wr = 0, r_rd = 0, r_wdat = 1;
  logic [IW-1:0] l_idx = '0, r_idx = '0;
  logic [DW-1:0] l_rdat, r_rdat;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  // model: 0 free, 1 left, 2 right
  int owner [NF];
  bit pend_l [NF];
  bit pend_r [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_sem_unit #(.NUM_FLAGS(NF), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .l_cs(l_cs), .l_wr(l_wr), .l_rd(l_rd), .l_idx(l_idx), .l_wdat(l_wdat), .l_rdat(l_rdat),
    .r_cs(r_cs), .r_wr(r_wr), .r_rd(r_rd), .r_idx(r_idx), .r_wdat(r_wdat), .r_rdat(r_rdat)
  );

  function automatic logic [DW-1:0] exp_rd(bit cs, bit rd, int idx, int side);
    if (cs && rd && owner[idx] == side) return '0;
    return '1;
  endfunction

  task automatic check_ports(string tag);
    logic [DW-1:0] el, er;
    el = exp_rd(l_cs, l_rd, int'(l_idx), 1);
    er = exp_rd(r_cs, r_rd, int'(r_idx), 2);
    checks++;
    if (l_rdat !== el) begin
      errors++;
      $display("FAIL %s left read: got %h expected %h", tag, l_rdat, el);
    end
    checks++;
    if (r_rdat !== er) begin
      errors++;
      $display("FAIL %s right read: got %h expected %h", tag, r_rdat, er);
    end
  endtask

  task automatic model_edge();
    if (l_cs && l_wr) pend_l[l_idx] = !l_wdat;
    if (r_cs && r_wr) pend_r[r_idx] = !r_wdat;
    for (int i = 0; i < NF; i++) begin
      if (owner[i] == 1 && !pend_l[i])      owner[i] = 0;
      else if (owner[i] == 2 && !pend_r[i]) owner[i] = 0;
      if (owner[i] == 0) begin
        if (pend_l[i])      owner[i] = 1;
        else if (pend_r[i]) owner[i] = 2;
      end
    end
  endtask

  // one cycle: drive after negedge, compare, then model follows posedge
  task automatic step(string tag,
                      bit lc, bit lw, bit lr, int li, bit ld,
                      bit rc, bit rw, bit rr, int ri, bit rd);
    @(negedge clk);
    l_cs = lc; l_wr = lw; l_rd = lr; l_idx = IW'(li); l_wdat = ld;
    r_cs = rc; r_wr = rw; r_rd = rr; r_idx = IW'(ri); r_wdat = rd;
    #(CLK_PERIOD/4);
    check_ports(tag);
    @(posedge clk);
    model_edge();
  endtask

  task automatic read_both(string tag, int i);
    step(tag, 1,0,1,i,1, 1,0,1,i,1);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NF; i++) begin owner[i] = 0; pend_l[i] = 0; pend_r[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: everything free after reset
    for (int i = 0; i < NF; i++) read_both("R1", i);

    // R2: left claims flag 2, reads back zero; R3 right sees ones
    step("R2", 1,1,0,2,0, 0,0,0,0,1);
    read_both("R2", 2);
    read_both("R3", 2);

    // R8: other flags unaffected
    for (int i = 0; i < NF; i++) read_both("R8", i);

    // R5: right requests while left holds, stays pending
    step("R5", 0,0,0,0,1, 1,1,0,2,0);
    read_both("R5", 2);
    // left releases; right takes over at that edge
    step("R5", 1,1,0,2,1, 0,0,0,0,1);
    read_both("R5", 2);

    // R4: right releases with nothing pending -> free
    step("R4", 0,0,0,0,1, 1,1,0,2,1);
    read_both("R4", 2);

    // R6: left owns 5, right requests then withdraws
    step("R6", 1,1,0,5,0, 0,0,0,0,1);
    step("R6", 0,0,0,0,1, 1,1,0,5,0);
    step("R6", 0,0,0,0,1, 1,1,0,5,1);
    read_both("R6", 5);
    step("R6", 1,1,0,5,1, 0,0,0,0,1);
    read_both("R6", 5);

    // R7: simultaneous request on free flag 7
    step("R7", 1,1,0,7,0, 1,1,0,7,0);
    read_both("R7", 7);
    step("R7", 1,1,0,7,1, 0,0,0,0,1);
    read_both("R7", 7);
    step("R7", 0,0,0,0,1, 1,1,0,7,1);
    read_both("R7", 7);

    // R9: strobes without select ignored; idle read data ones
    step("R9", 0,1,1,3,0, 0,1,1,3,0);
    read_both("R9", 3);
    step("R9", 1,0,0,3,1, 1,0,0,3,1);

    // R10: both claim different flags at once, then contend on each
    step("R10", 1,1,0,0,0, 1,1,0,1,0);
    step("R10", 1,1,1,1,0, 1,1,1,0,0);
    read_both("R10", 0);
    read_both("R10", 1);
    step("R10", 1,1,0,0,1, 1,1,0,1,1);
    read_both("R10", 0);
    read_both("R10", 1);
    step("R10", 1,1,0,1,1, 1,1,0,0,1);
    for (int i = 0; i < NF; i++) read_both("R1", i);

    finish_run();
  end
endmodule